// File: doc/BRIEF.md
# Programmable SRAM Bus Cycle Generator

This block turns single internal requests into SRAM-style cycles on an external bus for one chip-select area. A request carries an address, a read or write flag, four byte enables and write data. When the top three bits of the address name this block's area and the block is idle, the request is taken. The area's active-low chip select then frames the whole access. Inside that frame the block drives an active-low read strobe, which the memory can use directly as its output enable, or up to four active-low per-byte write strobes.

Each access has three phases. A programmable setup phase lasts 0 to 7 cycles, with the address and chip select valid and the strobes idle. Next comes the strobe phase: one base cycle plus 0 to 25 programmed wait cycles, stretched further while an external ready input is low. A programmable hold phase of 0 to 7 cycles follows, with the strobes released. An active-low bus-start marker flags the first strobe cycle and can optionally be asserted one cycle earlier. The bus can be 8, 16 or 32 bits wide. Narrow widths steer the addressed byte or halfword onto the low lanes. One cycle after the chip select is released, a one-cycle done pulse tells the requester that the access has finished. For reads, the captured data is valid at that point.

Top module: `sram_cycle_gen`

## Requirements
- R1: A request is accepted only when `req_valid` is high, the block is idle, and address bits 28..26 equal `AREA_CODE` (default 3'b100). Otherwise `bus_cs_n` stays high and no `req_done` pulse is produced.
- R2: Take S as `cfg_setup` at acceptance. The chip select goes low in the first cycle after acceptance. The strobe goes low S cycles later, in cycle S+1 counted from acceptance.
- R3: Take W as the effective wait count at acceptance. The strobe stays low for 1+W cycles. If W>0 and `bus_rdy` is low at the end of the last of those cycles, the strobe stays low. It is released after the first cycle whose end sees `bus_rdy` high.
- R4: When W is 0, `bus_rdy` is ignored and the strobe lasts exactly one cycle.
- R5: Take H as `cfg_hold` at acceptance. The chip select stays low for H cycles after the last strobe cycle and is one contiguous run of S+T+H cycles, where T is the strobe length.
- R6: `req_done` is high for exactly one cycle, the first cycle after the chip select returns high.
- R7: On a read, `bus_rd_n` is low during the strobe phase and all of `bus_we_n` stay high. `bus_din` is captured at the end of the last strobe cycle. The captured data is placed on `rd_data` as follows, with all other bits zero:
  - 32-bit width: as is.
  - 16-bit width: bits 15:0 go to halfword address[1].
  - 8-bit width: bits 7:0 go to byte lane address[1:0].
- R8: On a write, `bus_rd_n` stays high and `bus_we_n` is low only during the strobe phase, following the byte enables as follows:
  - 32-bit width: `bus_we_n[i]` = ~be[i].
  - 16-bit width: only bits 1:0, from be[2*a1+1:2*a1] with a1 = address[1].
  - 8-bit width: only bit 0, from be[address[1:0]].

  `bus_wdata` carries the selected lane of `req_wdata` on its low bits, with unused bits zero.
- R9: `bus_bs_n` is low in the first strobe cycle. When `cfg_bs_hold`=1 and S>=1, it is also low in the last setup cycle. It is high in every other cycle.
- R10: A programmed wait count above 25 behaves as 25.
- R11: `cfg_size` encodes the bus width as 2'b01 = 8 bits, 2'b10 = 16 bits, and 2'b00 or 2'b11 = 32 bits. With `cfg_bytectl`=1, code 2'b01 selects 16 bits.
- R12: Configuration is sampled only at acceptance, so changes during an access do not alter it. `req_ready` is low from the cycle after acceptance until the access returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 29 | Physical address |
| req_be | input | 4 | Byte enables |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Block idle, a request can be taken |
| req_done | output | 1 | One-cycle access-complete pulse |
| rd_data | output | 32 | Lane-aligned captured read data |
| cfg_size | input | 2 | Bus width code |
| cfg_bytectl | input | 1 | Byte-control variant (no 8-bit width) |
| cfg_wait | input | 5 | Programmed wait cycles |
| cfg_setup | input | 3 | Setup cycles before strobe |
| cfg_hold | input | 3 | Hold cycles after strobe |
| cfg_bs_hold | input | 1 | Early bus-start enable |
| bus_rdy | input | 1 | External ready, active high |
| bus_din | input | 32 | External read data |
| bus_addr | output | 29 | External address |
| bus_wdata | output | 32 | External write data |
| bus_cs_n | output | 1 | Area chip select, active low |
| bus_rd_n | output | 1 | Read strobe / output enable, active low |
| bus_we_n | output | 4 | Per-byte write strobes, active low |
| bus_bs_n | output | 1 | Bus-start marker, active low |

## Verification
The bench sweeps every setup and hold count against both bus-start settings. A design that miscounted either phase would show a shifted strobe or a chip-select run of the wrong length. The same sweep catches an early bus-start cycle that ignored the zero-setup case. Every wait count from 0 to 25 is run with ready held low past the programmed count, and a count of 30 is run as well. A design that sampled ready too early, failed to ignore it at zero waits, or failed to saturate the count would produce a strobe length that differs from the arithmetic expectation. The bench walks all widths and byte lanes for both directions, including the byte-control variant, alters the configuration mid-access, and sends an address from the wrong area. Wrong lane steering would show up as stray strobes or misplaced data. Configuration taken live instead of latched, or a decode that ignored the top address bits, would show up as a retimed cycle or a spurious chip select.

// File: rtl/sram_cyc_pkg.sv
package sram_cyc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_STROBE,
    PH_HOLD
  } phase_t;

  typedef enum logic [1:0] {
    BW_8,
    BW_16,
    BW_32
  } width_t;

  // 01 = 8 bits (16 when byte control is on), 10 = 16 bits, else 32 bits
  function automatic width_t decode_width(input logic [1:0] sz, input logic bytectl);
    width_t w;
    case (sz)
      2'b01:   w = bytectl ? BW_16 : BW_8;
      2'b10:   w = BW_16;
      default: w = BW_32;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/sram_area_decode.sv
module sram_area_decode #(
  parameter int          ADDR_W    = 29,
  parameter int          SEL_W     = 3,
  parameter logic [2:0]  AREA_CODE = 3'b100
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int TOP = ADDR_W - 1;

  assign hit = (addr[TOP -: SEL_W] == AREA_CODE[SEL_W-1:0]);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map
  import sram_cyc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int LB    = $clog2(LANES)
) (
  input  width_t            wr_width,
  input  logic [LB-1:0]     wr_lane,
  input  logic [LANES-1:0]  be,
  input  logic [DATA_W-1:0] wdata,
  output logic [LANES-1:0]  we_lanes,
  output logic [DATA_W-1:0] wdata_bus,
  input  width_t            rd_width,
  input  logic [LB-1:0]     rd_lane,
  input  logic [DATA_W-1:0] rdata_bus,
  output logic [DATA_W-1:0] rdata_aligned
);
  localparam int HB = LB - 1;

  logic [HB-1:0] wr_half;
  logic [HB-1:0] rd_half;

  assign wr_half = wr_lane[LB-1:1];
  assign rd_half = rd_lane[LB-1:1];

  always_comb begin
    we_lanes  = '0;
    wdata_bus = '0;
    case (wr_width)
      BW_8: begin
        we_lanes[0]     = be[wr_lane];
        wdata_bus[7:0]  = wdata[8*wr_lane +: 8];
      end
      BW_16: begin
        we_lanes[1:0]   = be[2*wr_half +: 2];
        wdata_bus[15:0] = wdata[16*wr_half +: 16];
      end
      default: begin
        we_lanes  = be;
        wdata_bus = wdata;
      end
    endcase
  end

  always_comb begin
    rdata_aligned = '0;
    case (rd_width)
      BW_8:    rdata_aligned[8*rd_lane +: 8]   = rdata_bus[7:0];
      BW_16:   rdata_aligned[16*rd_half +: 16] = rdata_bus[15:0];
      default: rdata_aligned = rdata_bus;
    endcase
  end

endmodule

// File: rtl/sram_phase_fsm.sv
module sram_phase_fsm
  import sram_cyc_pkg::*;
#(
  parameter int WAIT_W  = 5,
  parameter int SETUP_W = 3,
  parameter int HOLD_W  = 3,
  localparam int CW = (WAIT_W >= SETUP_W && WAIT_W >= HOLD_W) ? WAIT_W :
                      (SETUP_W >= HOLD_W) ? SETUP_W : HOLD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic               rdy,
  output phase_t             phase,
  output phase_t             nxt_phase,
  output logic               nxt_last_setup,
  output logic               strobe_end
);
  logic [CW-1:0]     cnt, ncnt;
  logic [WAIT_W-1:0] wait_q;
  logic [HOLD_W-1:0] hold_q;

  always_comb begin
    nxt_phase  = phase;
    ncnt       = cnt;
    strobe_end = 1'b0;
    case (phase)
      PH_IDLE: begin
        if (start) begin
          if (cfg_setup != '0) begin
            nxt_phase = PH_SETUP;
            ncnt      = CW'(cfg_setup) - CW'(1);
          end else begin
            nxt_phase = PH_STROBE;
            ncnt      = CW'(cfg_wait);
          end
        end
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          nxt_phase = PH_STROBE;
          ncnt      = CW'(wait_q);
        end else begin
          ncnt = cnt - CW'(1);
        end
      end
      PH_STROBE: begin
        if (cnt != '0) begin
          ncnt = cnt - CW'(1);
        end else if (wait_q != '0 && !rdy) begin
          ncnt = cnt;
        end else begin
          strobe_end = 1'b1;
          if (hold_q != '0) begin
            nxt_phase = PH_HOLD;
            ncnt      = CW'(hold_q) - CW'(1);
          end else begin
            nxt_phase = PH_IDLE;
          end
        end
      end
      default: begin
        if (cnt == '0) nxt_phase = PH_IDLE;
        else           ncnt = cnt - CW'(1);
      end
    endcase
  end

  assign nxt_last_setup = (nxt_phase == PH_SETUP) && (ncnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= PH_IDLE;
      cnt    <= '0;
      wait_q <= '0;
      hold_q <= '0;
    end else begin
      phase <= nxt_phase;
      cnt   <= ncnt;
      if (phase == PH_IDLE && start) begin
        wait_q <= cfg_wait;
        hold_q <= cfg_hold;
      end
    end
  end

endmodule

// File: rtl/sram_cycle_gen.sv
module sram_cycle_gen
  import sram_cyc_pkg::*;
#(
  parameter int         ADDR_W    = 29,
  parameter int         DATA_W    = 32,
  parameter logic [2:0] AREA_CODE = 3'b100,
  parameter int         WAIT_W    = 5,
  parameter int         MAX_WAIT  = 25,
  parameter int         SETUP_W   = 3,
  parameter int         HOLD_W    = 3,
  localparam int        LANES     = DATA_W / 8,
  localparam int        LB        = $clog2(LANES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [LANES-1:0]   req_be,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic               req_done,
  output logic [DATA_W-1:0]  rd_data,
  input  logic [1:0]         cfg_size,
  input  logic               cfg_bytectl,
  input  logic [WAIT_W-1:0]  cfg_wait,
  input  logic [SETUP_W-1:0] cfg_setup,
  input  logic [HOLD_W-1:0]  cfg_hold,
  input  logic               cfg_bs_hold,
  input  logic               bus_rdy,
  input  logic [DATA_W-1:0]  bus_din,
  output logic [ADDR_W-1:0]  bus_addr,
  output logic [DATA_W-1:0]  bus_wdata,
  output logic               bus_cs_n,
  output logic               bus_rd_n,
  output logic [LANES-1:0]   bus_we_n,
  output logic               bus_bs_n
);
  phase_t             phase, nxt_phase;
  logic               nxt_last_setup, strobe_end;
  logic               hit, accept;
  logic [WAIT_W-1:0]  wait_eff;
  width_t             width_in, width_q;
  logic [LB-1:0]      lane_q;
  logic               write_q, bs_q;
  logic [LANES-1:0]   we_in, we_q, we_sel;
  logic [DATA_W-1:0]  wdata_mapped, rdata_aligned;
  logic               write_sel, bs_sel;

  sram_area_decode #(
    .ADDR_W   (ADDR_W),
    .SEL_W    (3),
    .AREA_CODE(AREA_CODE)
  ) u_dec (
    .addr(req_addr),
    .hit (hit)
  );

  assign width_in  = decode_width(cfg_size, cfg_bytectl);
  assign wait_eff  = (cfg_wait > WAIT_W'(MAX_WAIT)) ? WAIT_W'(MAX_WAIT) : cfg_wait;
  assign req_ready = (phase == PH_IDLE);
  assign accept    = req_ready && req_valid && hit;

  sram_phase_fsm #(
    .WAIT_W (WAIT_W),
    .SETUP_W(SETUP_W),
    .HOLD_W (HOLD_W)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .start         (accept),
    .cfg_setup     (cfg_setup),
    .cfg_wait      (wait_eff),
    .cfg_hold      (cfg_hold),
    .rdy           (bus_rdy),
    .phase         (phase),
    .nxt_phase     (nxt_phase),
    .nxt_last_setup(nxt_last_setup),
    .strobe_end    (strobe_end)
  );

  sram_lane_map #(
    .DATA_W(DATA_W)
  ) u_lanes (
    .wr_width     (width_in),
    .wr_lane      (req_addr[LB-1:0]),
    .be           (req_be),
    .wdata        (req_wdata),
    .we_lanes     (we_in),
    .wdata_bus    (wdata_mapped),
    .rd_width     (width_q),
    .rd_lane      (lane_q),
    .rdata_bus    (bus_din),
    .rdata_aligned(rdata_aligned)
  );

  // The first strobe cycle may follow acceptance directly, so select live values then
  assign write_sel = accept ? req_write   : write_q;
  assign bs_sel    = accept ? cfg_bs_hold : bs_q;
  assign we_sel    = accept ? we_in       : we_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_cs_n  <= 1'b1;
      bus_rd_n  <= 1'b1;
      bus_we_n  <= '1;
      bus_bs_n  <= 1'b1;
      req_done  <= 1'b0;
      rd_data   <= '0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      width_q   <= BW_32;
      lane_q    <= '0;
      write_q   <= 1'b0;
      bs_q      <= 1'b0;
      we_q      <= '0;
    end else begin
      bus_cs_n <= (nxt_phase == PH_IDLE);
      bus_rd_n <= !((nxt_phase == PH_STROBE) && !write_sel);
      bus_we_n <= ((nxt_phase == PH_STROBE) && write_sel) ? ~we_sel : '1;
      bus_bs_n <= !(((nxt_phase == PH_STROBE) && (phase != PH_STROBE)) ||
                    (nxt_last_setup && bs_sel));
      req_done <= (nxt_phase == PH_IDLE) && (phase != PH_IDLE);
      if (accept) begin
        bus_addr  <= req_addr;
        bus_wdata <= wdata_mapped;
        width_q   <= width_in;
        lane_q    <= req_addr[LB-1:0];
        write_q   <= req_write;
        bs_q      <= cfg_bs_hold;
        we_q      <= we_in;
      end
      if (strobe_end && !write_q) rd_data <= rdata_aligned;
    end
  end

endmodule

// File: rtl/sram_cycle_gen_chk.sv
module sram_cycle_gen_chk
  import sram_cyc_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       req_valid,
  input logic       req_done,
  input logic       bus_cs_n,
  input logic       bus_rd_n,
  input logic [3:0] bus_we_n,
  input logic       bus_bs_n,
  input width_t     width_q
);

  assert_cs_needs_request_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_cs_n) |-> $past(req_valid));

  assert_strobe_inside_cs_R2: assert property (@(posedge clk) disable iff (rst)
    (!bus_rd_n || (bus_we_n != 4'hF)) |-> !bus_cs_n);

  assert_done_after_cs_R6: assert property (@(posedge clk) disable iff (rst)
    req_done |-> (bus_cs_n && $past(!bus_cs_n)));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (rst)
    req_done |=> !req_done);

  assert_no_rd_with_we_R7: assert property (@(posedge clk) disable iff (rst)
    !(!bus_rd_n && (bus_we_n != 4'hF)));

  assert_we_narrow8_R8: assert property (@(posedge clk) disable iff (rst)
    (width_q == BW_8) |-> (bus_we_n[3:1] == 3'b111));

  assert_we_narrow16_R8: assert property (@(posedge clk) disable iff (rst)
    (width_q == BW_16) |-> (bus_we_n[3:2] == 2'b11));

  assert_bs_inside_cs_R9: assert property (@(posedge clk) disable iff (rst)
    !bus_bs_n |-> !bus_cs_n);

endmodule

bind sram_cycle_gen sram_cycle_gen_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_done (req_done),
  .bus_cs_n (bus_cs_n),
  .bus_rd_n (bus_rd_n),
  .bus_we_n (bus_we_n),
  .bus_bs_n (bus_bs_n),
  .width_q  (width_q)
);

// File: tb/tb_sram_cycle_gen.sv
`timescale 1ns/1ps
module tb_sram_cycle_gen;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [28:0] req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, req_done;
  logic [31:0] rd_data;
  logic [1:0]  cfg_size = 2'b11;
  logic        cfg_bytectl = 1'b0;
  logic [4:0]  cfg_wait = '0;
  logic [2:0]  cfg_setup = '0, cfg_hold = '0;
  logic        cfg_bs_hold = 1'b0;
  logic        bus_rdy = 1'b1;
  logic [31:0] bus_din = '0;
  logic [28:0] bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_cs_n, bus_rd_n, bus_bs_n;
  logic [3:0]  bus_we_n;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  localparam int LIM = 62;

  always #2.5 clk = ~clk;

  sram_cycle_gen dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .req_ready(req_ready), .req_done(req_done), .rd_data(rd_data),
    .cfg_size(cfg_size), .cfg_bytectl(cfg_bytectl), .cfg_wait(cfg_wait),
    .cfg_setup(cfg_setup), .cfg_hold(cfg_hold), .cfg_bs_hold(cfg_bs_hold),
    .bus_rdy(bus_rdy), .bus_din(bus_din), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n),
    .bus_we_n(bus_we_n), .bus_bs_n(bus_bs_n)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, got=%0d cycles exp<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  function automatic int eff_width(input logic [1:0] sz, input bit bc);
    if (sz == 2'b01) return bc ? 16 : 8;
    if (sz == 2'b10) return 16;
    return 32;
  endfunction

  function automatic logic [31:0] din_of(input int k);
    return {8'h5A, 8'h3C, 8'(k), 8'(k + 8'h40)};
  endfunction

  task automatic run_access(input bit wr, input logic [1:0] lane, input logic [3:0] be,
                            input logic [1:0] sz, input bit bc, input int s, input int w,
                            input int h, input bit bs, input int kr, input bit scramble);
    int weff, e, t, n, bw, k_done, first_st;
    logic [3:0]  wexp;
    logic [31:0] wdexp, wdseen, rdexp, rdseen, wd;
    logic [63:0] cs_e, st_e, bs_e, cs_o, st_o, bs_o, dn_o;
    int weerr, rderr, rdy_busy;
    string tg;
    wd = 32'hC1D2_E3F4 ^ {4{8'(s * 16 + h)}};
    weff = (w > 25) ? 25 : w;
    e = (weff == 0) ? s + 1 : ((s + weff + 1 > kr) ? s + weff + 1 : kr);
    t = e - s;
    n = s + t + h;
    bw = eff_width(sz, bc);
    if (bw == 32) begin
      wexp = be; wdexp = wd; rdexp = din_of(e);
    end else if (bw == 16) begin
      wexp = (be >> (2 * lane[1])) & 4'h3;
      wdexp = (wd >> (16 * lane[1])) & 32'hFFFF;
      rdexp = (din_of(e) & 32'hFFFF) << (16 * lane[1]);
    end else begin
      wexp = (be >> lane) & 4'h1;
      wdexp = (wd >> (8 * lane)) & 32'hFF;
      rdexp = (din_of(e) & 32'hFF) << (8 * lane);
    end
    cs_e = '0; st_e = '0; bs_e = '0;
    for (int k = 1; k <= n; k++) cs_e[k] = 1'b1;
    if (!wr || wexp != 0) for (int k = s + 1; k <= e; k++) st_e[k] = 1'b1;
    bs_e[s + 1] = 1'b1;
    if (bs && s >= 1) bs_e[s] = 1'b1;
    cs_o = '0; st_o = '0; bs_o = '0; dn_o = '0;
    weerr = 0; rderr = 0; rdy_busy = 0; first_st = 0; k_done = 0;
    wdseen = '0; rdseen = '0;

    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = {3'b100, 24'h5A5A17, lane};
    req_be = be; req_wdata = wd;
    cfg_size = sz; cfg_bytectl = bc; cfg_wait = 5'(w); cfg_setup = 3'(s);
    cfg_hold = 3'(h); cfg_bs_hold = bs; bus_rdy = 1'b1;
    for (int k = 1; k <= LIM; k++) begin
      @(negedge clk);
      if (k == 1) begin
        req_valid = 1'b0;
        wdseen = bus_wdata;
        if (req_ready) rdy_busy++;
      end
      if (!bus_cs_n) cs_o[k] = 1'b1;
      if (!bus_rd_n || bus_we_n != 4'hF) begin
        st_o[k] = 1'b1;
        if (first_st == 0) first_st = k;
      end
      if (!bus_bs_n) bs_o[k] = 1'b1;
      if (req_done) begin dn_o[k] = 1'b1; k_done = k; rdseen = rd_data; end
      if (wr && !bus_rd_n) rderr++;
      if (!wr && bus_we_n != 4'hF) weerr++;
      if (wr && (k >= s + 1 && k <= e) && bus_we_n != ~wexp) weerr++;
      if (wr && !(k >= s + 1 && k <= e) && bus_we_n != 4'hF) weerr++;
      bus_rdy = (k >= kr);
      bus_din = din_of(k);
      if (scramble && k == 1) begin
        cfg_setup = 3'(7 - s); cfg_wait = 5'(w + 7); cfg_hold = 3'(7 - h);
        cfg_size = ~sz; cfg_bs_hold = ~bs;
      end
    end
    bus_rdy = 1'b1;
    $sformat(tg, "s=%0d w=%0d h=%0d bs=%0d kr=%0d wr=%0d bw=%0d ln=%0d", s, w, h, bs, kr, wr, bw, lane);
    chk({"R1/R5 cs run ", tg}, cs_o, cs_e);
    chk({"R2/R3/R4 strobe window ", tg}, st_o, st_e);
    chk({"R9 bus-start ", tg}, bs_o, bs_e);
    chk({"R6 done cycle ", tg}, dn_o, 64'd1 << (n + 1));
    chk({"R12 busy ready ", tg}, rdy_busy, 0);
    if (wr) begin
      chk({"R8 we lanes ", tg}, weerr, 0);
      chk({"R8 wdata lane ", tg}, wdseen, wdexp);
      chk({"R8 no read strobe ", tg}, rderr, 0);
    end else begin
      chk({"R7 no write strobe ", tg}, weerr, 0);
      chk({"R7 read data ", tg}, (k_done != 0) ? rdseen : 32'hDEAD_BEEF, rdexp);
    end
  endtask

  initial begin
    int miss;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reset cs_n", bus_cs_n, 1);
    chk("R7 reset rd_n", bus_rd_n, 1);
    chk("R8 reset we_n", bus_we_n, 4'hF);
    chk("R9 reset bs_n", bus_bs_n, 1);
    chk("R6 reset done", req_done, 0);
    chk("R12 reset ready", req_ready, 1);

    // R2 R5 R9: setup x hold x bus-start hold
    for (int s = 0; s < 8; s++)
      for (int h = 0; h < 8; h++)
        for (int b = 0; b < 2; b++)
          run_access(h[0], 2'd0, 4'hF, 2'b11, 1'b0, s, 2, h, b[0], 0, 1'b0);

    // R3 R4: each wait count with ready held low two cycles past the count
    for (int w = 0; w < 26; w++)
      run_access(1'b0, 2'd0, 4'hF, 2'b11, 1'b0, 1, w, 1, 1'b0, 1 + w + 3, 1'b0);
    run_access(1'b0, 2'd0, 4'hF, 2'b11, 1'b0, 0, 0, 0, 1'b0, 20, 1'b0);  // R4

    // R10: saturation of the wait count
    run_access(1'b0, 2'd0, 4'hF, 2'b11, 1'b0, 0, 30, 0, 1'b0, 0, 1'b0);
    run_access(1'b1, 2'd0, 4'hF, 2'b11, 1'b0, 2, 31, 1, 1'b1, 0, 1'b0);

    // R7 R8 R11: widths and lanes
    for (int z = 0; z < 4; z++)
      for (int l = 0; l < 4; l++)
        for (int d = 0; d < 2; d++) begin
          run_access(d[0], 2'(l), 4'b1011, 2'(z), 1'b0, 1, 1, 1, 1'b0, 0, 1'b0);
          if (z == 1) run_access(d[0], 2'(l), 4'b0110, 2'(z), 1'b1, 0, 0, 0, 1'b0, 0, 1'b0);
        end

    // R12: configuration changed during an access
    run_access(1'b0, 2'd1, 4'hF, 2'b10, 1'b0, 2, 3, 2, 1'b1, 0, 1'b1);
    run_access(1'b1, 2'd3, 4'hF, 2'b01, 1'b0, 3, 1, 4, 1'b0, 0, 1'b1);

    // R1: address of another area is never taken
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = {3'b101, 26'h0001234};
    cfg_setup = 3'd0; cfg_wait = 5'd0; cfg_hold = 3'd0;
    miss = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (!bus_cs_n || req_done || !req_ready) miss++;
    end
    req_valid = 1'b0;
    chk("R1 foreign area ignored", miss, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule